// File: doc/BRIEF.md
# Transmit Buffer Priority Selector

This block decides which of a small set of transmit message buffers a CAN-style controller should send next. Every buffer owns an 8-bit local priority value and an empty flag supplied by the buffer logic. A buffer with its empty flag clear holds a loaded message and competes for selection. The block compares the pending buffers every clock and presents the winner in two forms: one-hot and binary index. A valid strobe goes with them, and all three outputs are registered.

Software reaches the per-buffer priority values through a single register window. A buffer-select register chooses which buffer the window points at. The window only opens when the addressed buffer is empty, so a priority value cannot change under a message that is waiting to go out. Bus arbitration, bit timing and payload storage belong to other blocks.

Top module: `tx_prio_select`

## Requirements
- R1: With the buffer-select register addressing an empty buffer, a write to the priority window (reg_addr = 1) stores the 8-bit value, and a read of the window returns it unchanged.
- R2: Among pending buffers (empty flag 0), the buffer holding the numerically smallest priority value is reported as the winner. 0x00 beats 0xFF.
- R3: When two or more pending buffers share the smallest value, the one with the lowest index wins.
- R4: Buffers whose empty flag is 1 never win, whatever their priority value.
- R5: When no buffer is pending, win_valid is 0, win_onehot is 0 and win_idx is 0. This is also the state after reset.
- R6: The winner outputs are registered. A change on tx_empty or a priority value shows at the outputs after exactly one rising clock edge.
- R7: If the addressed buffer is not empty, a window write leaves its priority unchanged and a window read returns 0.
- R8: The buffer-select register (reg_addr = 0, bit i for buffer i) addresses only its lowest set bit when several bits are set. When it is zero, no buffer is addressed: window reads return 0 and window writes change nothing.
- R9: While win_valid is 1, win_onehot has exactly one bit set, and that bit is at position win_idx.
- R10: The buffer-select register resets to 0 and reads back the value last written, zero-extended to 8 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_empty | input | NBUF | Empty flag per buffer, 1 = empty, 0 = pending |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = buffer-select register, 1 = priority window |
| reg_wdata | input | PW | Register write data |
| reg_rdata | output | PW | Register read data (combinational) |
| win_valid | output | 1 | A pending buffer has been selected |
| win_onehot | output | NBUF | One-hot winner |
| win_idx | output | $clog2(NBUF) | Binary index of the winner |

## Verification
On every cycle, the bound checker confirms that the winner is consistent: a valid winner is one-hot, its position equals the index, the outputs are zero when idle, and the chosen buffer was pending one edge earlier. It also confirms that an all-empty cycle gives no winner on the next cycle. Only the directed scenarios can show that the smallest value wins, that ties fall to the lower index, and that the outputs appear one edge late. They also cover the access rules of the priority window: a blocked write, the zero read, and lowest-bit decoding of the select register. Each of these depends on priority contents that the checker does not model.

// File: rtl/tx_prio_select.sv
module tx_prio_select #(
  parameter int NBUF = 3,
  parameter int PW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NBUF-1:0] tx_empty,
  input  logic            reg_wr,
  input  logic            reg_addr,
  input  logic [PW-1:0]   reg_wdata,
  output logic [PW-1:0]   reg_rdata,
  output logic            win_valid,
  output logic [NBUF-1:0] win_onehot,
  output logic [(NBUF>1 ? $clog2(NBUF) : 1)-1:0] win_idx
);
  localparam int IW = (NBUF > 1) ? $clog2(NBUF) : 1;
  localparam logic ADDR_SEL  = 1'b0;
  localparam logic ADDR_PRIO = 1'b1;

  logic [PW-1:0]   prio_q [NBUF];
  logic [NBUF-1:0] sel_q;
  logic [NBUF-1:0] sel_eff;
  logic [NBUF-1:0] open_win;
  logic            found;
  logic [IW-1:0]   best_idx;
  logic [PW-1:0]   best_val;

  assign sel_eff  = sel_q & (~sel_q + NBUF'(1));
  assign open_win = sel_eff & tx_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      sel_q <= '0;
    else if (reg_wr && reg_addr == ADDR_SEL)
      sel_q <= reg_wdata[NBUF-1:0];
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NBUF; i++)
      if (reg_wr && reg_addr == ADDR_PRIO && open_win[i])
        prio_q[i] <= reg_wdata;
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_SEL)
      reg_rdata[NBUF-1:0] = sel_q;
    else
      for (int i = 0; i < NBUF; i++)
        if (open_win[i]) reg_rdata = prio_q[i];
  end

  always_comb begin
    found    = 1'b0;
    best_idx = '0;
    best_val = '0;
    for (int i = 0; i < NBUF; i++) begin
      if (!tx_empty[i] && (!found || prio_q[i] < best_val)) begin
        found    = 1'b1;
        best_idx = IW'(i);
        best_val = prio_q[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_valid  <= 1'b0;
      win_onehot <= '0;
      win_idx    <= '0;
    end else begin
      win_valid  <= found;
      win_onehot <= found ? (NBUF'(1) << best_idx) : '0;
      win_idx    <= found ? best_idx : '0;
    end
  end
endmodule

// File: rtl/tx_prio_select_chk.sv
module tx_prio_select_chk #(
  parameter int NBUF = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NBUF-1:0] tx_empty,
  input logic            win_valid,
  input logic [NBUF-1:0] win_onehot,
  input logic [(NBUF>1 ? $clog2(NBUF) : 1)-1:0] win_idx
);
  AST_ONEHOT_WIN: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_onehot)); // R9
  AST_VALID_AGREES: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid == (win_onehot != '0)); // R5
  AST_IDX_AGREES: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> (win_onehot == (NBUF'(1) << win_idx))); // R9
  AST_IDLE_IDX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !win_valid |-> (win_idx == '0)); // R5
  AST_WINNER_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> (($past(tx_empty) & win_onehot) == '0)); // R4
  AST_ALL_EMPTY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(&tx_empty) |-> !win_valid); // R5
endmodule

bind tx_prio_select tx_prio_select_chk #(.NBUF(NBUF)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_empty(tx_empty),
  .win_valid(win_valid), .win_onehot(win_onehot), .win_idx(win_idx)
);

// File: tb/tb_tx_prio_select.sv
module tb_tx_prio_select;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [2:0] tx_empty = 3'b111;
  logic       reg_wr = 0;
  logic       reg_addr = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic       win_valid;
  logic [2:0] win_onehot;
  logic [1:0] win_idx;
  int checks = 0;
  int errors = 0;

  tx_prio_select dut (
    .clk(clk), .rst_n(rst_n), .tx_empty(tx_empty), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .win_valid(win_valid), .win_onehot(win_onehot), .win_idx(win_idx)
  );

  always #10 clk = ~clk;

  task automatic check_win(input logic v, input logic [2:0] oh, input logic [1:0] idx, input string req);
    checks++;
    if (win_valid !== v || win_onehot !== oh || win_idx !== idx) begin
      errors++;
      $display("FAIL %s: winner v=%b oh=%b idx=%0d, expected v=%b oh=%b idx=%0d",
               req, win_valid, win_onehot, win_idx, v, oh, idx);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd_chk(input logic a, input logic [7:0] exp, input string req);
    @(negedge clk);
    reg_addr = a;
    #1;
    checks++;
    if (reg_rdata !== exp) begin
      errors++;
      $display("FAIL %s: read addr=%0d got %h, expected %h", req, a, reg_rdata, exp);
    end
  endtask

  task automatic set_empty(input logic [2:0] e);
    @(negedge clk);
    tx_empty = e;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check_win(1'b0, 3'b000, 2'd0, "R5 reset");
    rd_chk(1'b0, 8'h00, "R10 select reset");
  endtask

  task automatic t_program();
    wr(1'b0, 8'h01); wr(1'b1, 8'h40); rd_chk(1'b1, 8'h40, "R1 buf0");
    wr(1'b0, 8'h02); wr(1'b1, 8'h20); rd_chk(1'b1, 8'h20, "R1 buf1");
    wr(1'b0, 8'h04); wr(1'b1, 8'h30); rd_chk(1'b1, 8'h30, "R1 buf2");
    rd_chk(1'b0, 8'h04, "R10 select readback");
  endtask

  task automatic t_lowest();
    @(negedge clk);
    tx_empty = 3'b000;
    #1;
    check_win(1'b0, 3'b000, 2'd0, "R6 before edge");
    @(negedge clk);
    check_win(1'b1, 3'b010, 2'd1, "R2 R6 lowest value");
  endtask

  task automatic t_pending();
    set_empty(3'b010);
    check_win(1'b1, 3'b100, 2'd2, "R4 skip empty buf1");
    set_empty(3'b011);
    check_win(1'b1, 3'b100, 2'd2, "R4 single pending");
  endtask

  task automatic t_idle();
    set_empty(3'b111);
    check_win(1'b0, 3'b000, 2'd0, "R5 none pending");
  endtask

  task automatic t_tie();
    wr(1'b0, 8'h04); wr(1'b1, 8'h20);
    set_empty(3'b000);
    check_win(1'b1, 3'b010, 2'd1, "R3 tie buf1/buf2");
    set_empty(3'b111);
    wr(1'b0, 8'h01); wr(1'b1, 8'h20);
    set_empty(3'b000);
    check_win(1'b1, 3'b001, 2'd0, "R3 three-way tie");
  endtask

  task automatic t_deny();
    wr(1'b0, 8'h02); wr(1'b1, 8'h05);
    rd_chk(1'b1, 8'h00, "R7 read while pending");
    @(negedge clk);
    check_win(1'b1, 3'b001, 2'd0, "R7 blocked write no effect");
    set_empty(3'b111);
    rd_chk(1'b1, 8'h20, "R7 value kept");
  endtask

  task automatic t_sel_multi();
    wr(1'b0, 8'h06); wr(1'b1, 8'h11);
    wr(1'b0, 8'h02); rd_chk(1'b1, 8'h11, "R8 lowest set bit buf1");
    wr(1'b0, 8'h04); rd_chk(1'b1, 8'h20, "R8 buf2 untouched");
    wr(1'b0, 8'h00); rd_chk(1'b1, 8'h00, "R8 zero select read");
    wr(1'b1, 8'h77);
    wr(1'b0, 8'h01); rd_chk(1'b1, 8'h20, "R8 zero select write buf0");
    wr(1'b0, 8'h04); rd_chk(1'b1, 8'h20, "R8 zero select write buf2");
  endtask

  task automatic t_extremes();
    wr(1'b0, 8'h01); wr(1'b1, 8'hFF);
    wr(1'b0, 8'h02); wr(1'b1, 8'hFF);
    wr(1'b0, 8'h04); wr(1'b1, 8'h00);
    set_empty(3'b000);
    check_win(1'b1, 3'b100, 2'd2, "R2 zero beats 0xFF");
    set_empty(3'b100);
    check_win(1'b1, 3'b001, 2'd0, "R3 tie at 0xFF");
    set_empty(3'b111);
    check_win(1'b0, 3'b000, 2'd0, "R5 back to idle");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_program();
    t_lowest();
    t_pending();
    t_idle();
    t_tie();
    t_deny();
    t_sel_multi();
    t_extremes();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule